// File: doc/BRIEF.md
# Branch Target Cache

This block sits beside the fetch stage and remembers where recently resolved conditional branches went. Each cycle the fetch unit presents the address it is fetching, together with the immediate offset of the branch found there. If the cache holds a matching entry, the stored target comes back in the same cycle and the fetch unit can redirect at once, without waiting for the branch to resolve. If there is no match, a static rule gives a guess: a backward branch is taken and a forward branch is not, with the target computed as address plus offset.

When a branch resolves, the execute side drives the update port with the branch address, its real target, its kind and whether the earlier guess was wrong. Only conditional kinds are written. The cache is direct mapped: halfword address bits select the entry, and the remaining upper bits form the tag. An entry that guesses wrong twice in a row is dropped. A conflicting branch that maps to an occupied slot replaces the old one. A single invalidate-all input empties the whole cache.

Top module: `brtgt_cache`

## Requirements
- R1: After reset deasserts, every lookup misses (`lkp_hit_o` = 0) until an entry has been written.
- R2: The entry index is `pc[IDX_W:1]`, with IDX_W = log2(ENTRIES), which is bits [6:1] for 64 entries. The tag is `pc[ADDR_W-1:IDX_W+1]`. Bit 0 of the address takes no part in matching. Two addresses with the same index and different tags never hit on each other's entry.
- R3: On a lookup that hits, in the same cycle, `lkp_hit_o` = 1, `lkp_taken_o` = 1, `lkp_target_o` = the stored target and `lkp_kind_o` = the stored kind. The entry is visible from the cycle after the update edge.
- R4: Branch kind codes are 0 = unconditional direct, 1 = unconditional indirect, 2 = conditional direct and 3 = conditional indirect; bit 1 marks a conditional branch. An update of kind 0 or 1 writes nothing, and a later lookup of that address still misses.
- R5: On a miss, `lkp_hit_o` = 0 and `lkp_kind_o` = 0. `lkp_taken_o` equals the sign bit of `lkp_ofs_i`, and `lkp_target_o` = `lkp_pc_i` + sign-extended `lkp_ofs_i`.
- R6: A conditional update whose index and tag match a valid entry overwrites that entry's target and kind, and stores its mispredict flag as the entry's last outcome.
- R7: A conditional update with `upd_mispred_i` = 1, on a resident entry whose last outcome was also a mispredict, invalidates that entry. A correct outcome in between clears the streak. A new allocation stores its own mispredict flag as the last outcome.
- R8: A conditional update whose tag differs from the occupant of its index replaces that occupant, and the old address then misses.
- R9: `inv_all_i` clears every valid bit at the next edge. It wins over an update in the same cycle, so that update is not kept.
- R10: A lookup in the same cycle as an update to the same index returns the contents from before that update.
- R11: While `lkp_valid_i` = 0, `lkp_hit_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inv_all_i | input | 1 | Clear all entries at the next edge |
| lkp_valid_i | input | 1 | Lookup request qualifier |
| lkp_pc_i | input | ADDR_W | Fetch address looked up |
| lkp_ofs_i | input | OFS_W | Immediate offset of the branch at the fetch address |
| lkp_hit_o | output | 1 | Tag matched a valid entry |
| lkp_taken_o | output | 1 | Predicted direction |
| lkp_target_o | output | ADDR_W | Predicted next fetch address |
| lkp_kind_o | output | 2 | Stored branch kind on a hit, 0 on a miss |
| upd_valid_i | input | 1 | Resolved-branch update strobe |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_target_i | input | ADDR_W | Resolved target |
| upd_kind_i | input | 2 | Branch kind code |
| upd_mispred_i | input | 1 | The prediction for this branch was wrong |

## Verification
The bench builds the cache with its defaults: 64 entries, 32-bit addresses and 12-bit offsets. With 64 entries the index comes from bits [6:1], so addresses 0x80 apart alias on purpose. This gives direct conflict, replacement and same-index read-during-write cases without having to fill the array. The 12-bit offset makes the sign bit easy to drive either way, so both directions of the static guess can be exercised.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
  typedef enum logic [1:0] {
    BK_JMP     = 2'd0,
    BK_JMP_IND = 2'd1,
    BK_CND     = 2'd2,
    BK_CND_IND = 2'd3
  } br_kind_e;

  function automatic logic is_cond(logic [1:0] k);
    return k[1];
  endfunction
endpackage

// File: rtl/brtgt_index.sv
module brtgt_index #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  localparam int TAG_W = ADDR_W - IDX_W - 1
) (
  input  logic [ADDR_W-2:0] hw_pc_i,  // halfword address, pc[ADDR_W-1:1]
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  assign idx_o = hw_pc_i[IDX_W-1:0];
  assign tag_o = hw_pc_i[ADDR_W-2:IDX_W];
endmodule

// File: rtl/brtgt_static.sv
module brtgt_static #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 12
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);
  logic [ADDR_W-1:0] ofs_sext;

  assign ofs_sext = {{(ADDR_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
  assign taken_o  = ofs_i[OFS_W-1];  // backward taken, forward not
  assign target_o = pc_i + ofs_sext;
endmodule

// File: rtl/brtgt_store.sv
module brtgt_store #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 25,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_all_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_target_i,
  input  logic [1:0]        wr_kind_i,
  input  logic              wr_mispred_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [ADDR_W-1:0] rd_target_o,
  output logic [1:0]        rd_kind_o
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] wrong_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0]  target_q [ENTRIES];
  logic [1:0]         kind_q   [ENTRIES];

  logic wr_resident;
  logic wr_drop;

  assign wr_resident = valid_q[wr_idx_i] && (tag_q[wr_idx_i] == wr_tag_i);
  // second wrong guess in a row on a resident entry retires it
  assign wr_drop     = wr_resident && wrong_q[wr_idx_i] && wr_mispred_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (inv_all_i) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= !wr_drop;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !inv_all_i) begin
      tag_q[wr_idx_i]    <= wr_tag_i;
      target_q[wr_idx_i] <= wr_target_i;
      kind_q[wr_idx_i]   <= wr_kind_i;
      wrong_q[wr_idx_i]  <= wr_mispred_i;
    end
  end

  // read is combinational on registered state: a same-cycle write is not seen
  assign rd_valid_o  = valid_q[rd_idx_i];
  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_target_o = target_q[rd_idx_i];
  assign rd_kind_o   = kind_q[rd_idx_i];
endmodule

// File: rtl/brtgt_cache.sv
module brtgt_cache
  import brtgt_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_all_i,
  input  logic              lkp_valid_i,
  input  logic [ADDR_W-1:0] lkp_pc_i,
  input  logic [OFS_W-1:0]  lkp_ofs_i,
  output logic              lkp_hit_o,
  output logic              lkp_taken_o,
  output logic [ADDR_W-1:0] lkp_target_o,
  output logic [1:0]        lkp_kind_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic [1:0]        upd_kind_i,
  input  logic              upd_mispred_i
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - 1;

  logic [IDX_W-1:0]  lkp_idx, upd_idx;
  logic [TAG_W-1:0]  lkp_tag, upd_tag;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_target;
  logic [1:0]        rd_kind;
  logic              st_taken;
  logic [ADDR_W-1:0] st_target;
  logic              upd_alloc;
  logic              hit;

  brtgt_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lkp_ix (
    .hw_pc_i(lkp_pc_i[ADDR_W-1:1]), .idx_o(lkp_idx), .tag_o(lkp_tag)
  );

  brtgt_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_upd_ix (
    .hw_pc_i(upd_pc_i[ADDR_W-1:1]), .idx_o(upd_idx), .tag_o(upd_tag)
  );

  assign upd_alloc = upd_valid_i && is_cond(upd_kind_i);

  brtgt_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inv_all_i   (inv_all_i),
    .wr_en_i     (upd_alloc),
    .wr_idx_i    (upd_idx),
    .wr_tag_i    (upd_tag),
    .wr_target_i (upd_target_i),
    .wr_kind_i   (upd_kind_i),
    .wr_mispred_i(upd_mispred_i),
    .rd_idx_i    (lkp_idx),
    .rd_valid_o  (rd_valid),
    .rd_tag_o    (rd_tag),
    .rd_target_o (rd_target),
    .rd_kind_o   (rd_kind)
  );

  brtgt_static #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_static (
    .pc_i(lkp_pc_i), .ofs_i(lkp_ofs_i), .taken_o(st_taken), .target_o(st_target)
  );

  assign hit          = lkp_valid_i && rd_valid && (rd_tag == lkp_tag);
  assign lkp_hit_o    = hit;
  assign lkp_taken_o  = hit || st_taken;
  assign lkp_target_o = hit ? rd_target : st_target;
  assign lkp_kind_o   = hit ? rd_kind : 2'd0;
endmodule

// File: rtl/brtgt_cache_chk.sv
module brtgt_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inv_all_i,
  input logic              lkp_valid_i,
  input logic [ADDR_W-1:0] lkp_pc_i,
  input logic [OFS_W-1:0]  lkp_ofs_i,
  input logic              lkp_hit_o,
  input logic              lkp_taken_o,
  input logic [ADDR_W-1:0] lkp_target_o,
  input logic [1:0]        lkp_kind_o,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_pc_i,
  input logic [ADDR_W-1:0] upd_target_i,
  input logic [1:0]        upd_kind_i,
  input logic              upd_mispred_i
);
  logic [ADDR_W-1:0] ofs_sext;
  assign ofs_sext = {{(ADDR_W-OFS_W){lkp_ofs_i[OFS_W-1]}}, lkp_ofs_i};

  assert_miss_static_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_hit_o |-> (lkp_taken_o == lkp_ofs_i[OFS_W-1]) &&
                   (lkp_target_o == lkp_pc_i + ofs_sext) && (lkp_kind_o == 2'd0));

  assert_inv_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> !lkp_hit_o);

  assert_only_cond_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> lkp_kind_o[1]);

  assert_fill_visible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd_valid_i && upd_kind_i[1] && !upd_mispred_i && !inv_all_i) &&
     lkp_valid_i && (lkp_pc_i == $past(upd_pc_i)))
    |-> lkp_hit_o && lkp_taken_o && (lkp_target_o == $past(upd_target_i)));

  assert_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |-> !lkp_hit_o);
endmodule

bind brtgt_cache brtgt_cache_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .inv_all_i(inv_all_i),
  .lkp_valid_i(lkp_valid_i), .lkp_pc_i(lkp_pc_i), .lkp_ofs_i(lkp_ofs_i),
  .lkp_hit_o(lkp_hit_o), .lkp_taken_o(lkp_taken_o), .lkp_target_o(lkp_target_o),
  .lkp_kind_o(lkp_kind_o), .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i),
  .upd_target_i(upd_target_i), .upd_kind_i(upd_kind_i), .upd_mispred_i(upd_mispred_i)
);

// File: tb/brtgt_cache_tb.sv
`timescale 1ns/1ps
module brtgt_cache_tb;
  localparam int AW = 32;
  localparam int OW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inv_all = 1'b0;
  logic          lkp_valid = 1'b0;
  logic [AW-1:0] lkp_pc = '0;
  logic [OW-1:0] lkp_ofs = '0;
  logic          lkp_hit, lkp_taken;
  logic [AW-1:0] lkp_target;
  logic [1:0]    lkp_kind;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic [AW-1:0] upd_target = '0;
  logic [1:0]    upd_kind = '0;
  logic          upd_mispred = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic          hit;
    logic          taken;
    logic [AW-1:0] tgt;
    logic [1:0]    kind;
    bit            hit_only;
    string         rq;
  } exp_t;
  exp_t sb_q[$];

  always #2ns clk = ~clk;

  brtgt_cache #(.ENTRIES(64), .ADDR_W(AW), .OFS_W(OW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .inv_all_i(inv_all),
    .lkp_valid_i(lkp_valid), .lkp_pc_i(lkp_pc), .lkp_ofs_i(lkp_ofs),
    .lkp_hit_o(lkp_hit), .lkp_taken_o(lkp_taken), .lkp_target_o(lkp_target),
    .lkp_kind_o(lkp_kind), .upd_valid_i(upd_valid), .upd_pc_i(upd_pc),
    .upd_target_i(upd_target), .upd_kind_i(upd_kind), .upd_mispred_i(upd_mispred)
  );

  // one cycle of stimulus; optional expected lookup result pushed to scoreboard
  task automatic step(input bit uv, input logic [AW-1:0] upc, input logic [AW-1:0] utgt,
                      input logic [1:0] uk, input bit umis, input bit inv,
                      input bit lv, input logic [AW-1:0] lpc, input logic [OW-1:0] lofs,
                      input bit chk, input bit e_hit, input logic [AW-1:0] e_tgt,
                      input logic [1:0] e_kind, input bit hit_only, input string rq);
    exp_t e;
    @(negedge clk);
    upd_valid = uv; upd_pc = upc; upd_target = utgt; upd_kind = uk; upd_mispred = umis;
    inv_all = inv; lkp_valid = lv; lkp_pc = lpc; lkp_ofs = lofs;
    if (chk) begin
      e.hit = e_hit; e.taken = e_hit | lofs[OW-1];
      e.tgt = e_hit ? e_tgt : lpc + {{(AW-OW){lofs[OW-1]}}, lofs};
      e.kind = e_hit ? e_kind : 2'd0; e.hit_only = hit_only; e.rq = rq;
      sb_q.push_back(e);
    end
  endtask

  task automatic upd(input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                     input logic [1:0] k, input bit mis);
    step(1, pc, tgt, k, mis, 0, 0, '0, '0, 0, 0, '0, '0, 0, "");
  endtask

  task automatic look_hit(input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                          input logic [1:0] k, input string rq);
    step(0, '0, '0, '0, 0, 0, 1, pc, 12'h004, 1, 1, tgt, k, 0, rq);
  endtask

  task automatic look_miss(input logic [AW-1:0] pc, input logic [OW-1:0] ofs,
                           input string rq);
    step(0, '0, '0, '0, 0, 0, 1, pc, ofs, 1, 0, '0, '0, 0, rq);
  endtask

  // monitor: compares one cycle's lookup result 1 ns after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #1ns;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (e.hit_only) begin
          if (lkp_hit !== e.hit) begin
            n_bad++;
            $display("FAIL %s: hit=%0b expected %0b", e.rq, lkp_hit, e.hit);
          end
        end else if (lkp_hit !== e.hit || lkp_taken !== e.taken ||
                     lkp_target !== e.tgt || lkp_kind !== e.kind) begin
          n_bad++;
          $display("FAIL %s: hit=%0b taken=%0b tgt=%h kind=%0d expected hit=%0b taken=%0b tgt=%h kind=%0d",
                   e.rq, lkp_hit, lkp_taken, lkp_target, lkp_kind,
                   e.hit, e.taken, e.tgt, e.kind);
        end
      end
    end
  end

  initial begin
    #80000ns;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R5: empty after reset, forward and backward static guesses
    look_miss(32'h0000_0100, 12'h010, "R1");
    look_miss(32'h1000_0040, 12'hFF0, "R1_R5");

    // R3: fill then hit
    upd(32'h1000_0040, 32'h1000_0000, 2'd2, 0);
    look_hit(32'h1000_0040, 32'h1000_0000, 2'd2, "R3");
    // R2: bit 0 ignored; same index, other tag misses
    look_hit(32'h1000_0041, 32'h1000_0000, 2'd2, "R2");
    look_miss(32'h1000_00C0, 12'hFF0, "R2_R5");

    // R4: unconditional kinds are not stored
    upd(32'h2000_0010, 32'h2000_8000, 2'd0, 0);
    upd(32'h2000_0010, 32'h2000_8000, 2'd1, 0);
    look_miss(32'h2000_0010, 12'h004, "R4");

    // R8: conflicting allocation replaces occupant
    upd(32'h1000_00C0, 32'h3000_0000, 2'd3, 0);
    look_hit(32'h1000_00C0, 32'h3000_0000, 2'd3, "R8");
    look_miss(32'h1000_0040, 12'h000, "R8");

    // R10: same-cycle update and lookup to same index sees old contents
    step(1, 32'h1000_0040, 32'h4444_0000, 2'd2, 0, 0,
         1, 32'h1000_00C0, 12'h004, 1, 1, 32'h3000_0000, 2'd3, 0, "R10");
    look_miss(32'h1000_00C0, 12'h004, "R10");
    look_hit(32'h1000_0040, 32'h4444_0000, 2'd2, "R10");

    // R6 / R7: first mispredict updates, second in a row invalidates
    upd(32'h1000_0040, 32'h5555_0000, 2'd3, 1);
    look_hit(32'h1000_0040, 32'h5555_0000, 2'd3, "R6");
    upd(32'h1000_0040, 32'h5555_0000, 2'd3, 1);
    look_miss(32'h1000_0040, 12'h020, "R7");

    // R7: correct outcome between mispredicts clears the streak
    upd(32'h0000_0102, 32'h0000_0200, 2'd2, 1);
    upd(32'h0000_0102, 32'h0000_0220, 2'd2, 0);
    upd(32'h0000_0102, 32'h0000_0240, 2'd2, 1);
    look_hit(32'h0000_0102, 32'h0000_0240, 2'd2, "R7");
    upd(32'h0000_0102, 32'h0000_0240, 2'd2, 1);
    look_miss(32'h0000_0102, 12'h800, "R7");

    // R9: invalidate-all clears and beats a same-cycle update
    upd(32'h0000_0200, 32'h0000_0300, 2'd2, 0);
    upd(32'h0000_0106, 32'h0000_0600, 2'd2, 0);
    look_hit(32'h0000_0200, 32'h0000_0300, 2'd2, "R9");
    step(1, 32'h0000_0204, 32'h0000_0400, 2'd2, 0, 1, 0, '0, '0, 0, 0, '0, '0, 0, "");
    look_miss(32'h0000_0200, 12'h004, "R9");
    look_miss(32'h0000_0204, 12'h004, "R9");
    look_miss(32'h0000_0106, 12'hFFC, "R9");

    // R11: no hit without a lookup request
    upd(32'h0000_0208, 32'h0000_0500, 2'd2, 0);
    step(0, '0, '0, '0, 0, 0, 0, 32'h0000_0208, 12'h004, 1, 0, '0, '0, 1, "R11");
    look_hit(32'h0000_0208, 32'h0000_0500, 2'd2, "R11");

    step(0, '0, '0, '0, 0, 0, 0, '0, '0, 0, 0, '0, '0, 0, "");
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule